// File: doc/BRIEF.md
# SMII Inter-Frame Status Monitor

This block sits on the receive side of a serial media-independent link and inspects the line while no frame is in progress. During that idle gap the physical layer device uses each serial segment to report its own condition, such as link, speed and duplex, instead of frame data. The monitor shifts each segment in from the receive bit line. It keeps the status byte of every gap segment in a received-status register. It then compares that byte, one bit at a time, with a value that software has written into an expected-status register.

Every bit that disagrees with its expected value sets the bit in the same position of a sticky event register. A mask register chooses which event bits may drive the interrupt line. Software reads and writes the four registers through a small synchronous port. An event bit is cleared by writing 1 to its position.

Top module: `smii_gap_mon`

## Requirements
- R1: A segment is 10 serial bits. Its first bit is received in the cycle in which `syncIn` is high, and that bit is the carrier bit, which is ignored. Bit index 1 is the data-valid bit. Indexes 2 to 9 carry the status byte, least significant bit first. The received-status register takes the new byte at the clock edge that samples index 9.
- R2: A segment whose data-valid bit is 1 is frame data. It leaves the status, event and interrupt state unchanged.
- R3: A segment is captured only if `modeSmii` is high in the cycle of its last bit. When it is not captured, the status and event registers are unchanged.
- R4: At capture, every bit of the captured byte that differs from the same bit of the expected-status register (address 1) sets that bit of the event register (address 2), in the same edge. Event bits whose status bit matches are left as they were.
- R5: Writing to address 2 clears the event bits written as 1 and leaves the other event bits alone. When the same edge also brings a new mismatch on a bit, that bit ends up set.
- R6: `irqOut` is a register that equals the OR over all bits of (event AND mask), one clock after the event or mask register changes. The mask register is at address 3.
- R7: A `syncIn` pulse in the middle of a segment drops the partial segment and starts a new one. Bits that arrive after index 9 without a new sync pulse are ignored.
- R8: After reset, all four registers read 0 and `irqOut` is 0.
- R9: `regRdData` shows the register selected by `regAddr` in the same cycle: 0 status, 1 expected, 2 event, 3 mask. Writes to address 0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| modeSmii | input | 1 | Gap capture enabled when high |
| syncIn | input | 1 | Marks the first bit of a segment |
| rxBit | input | 1 | Serial receive bit |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| irqOut | output | 1 | Registered interrupt request |

## Verification
If the bit counter drifts, the captured byte comes out shifted or the data-valid bit is misread. Either fault shows in the status register at the first segment that follows. A fault in the event logic shows up in two ways: bits set where nothing differed, or bits lost on a clear that did not name them. Both are visible on the next read of address 2, and one clock later `irqOut` disagrees with the event and mask values that were read. The bench covers every status byte, including the case where a clear and a mismatch reach the event register on the same edge.

// File: rtl/smii_gap_pkg.sv
package smii_gap_pkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_EXPECT = 2'd1;
  localparam logic [1:0] ADDR_EVENT  = 2'd2;
  localparam logic [1:0] ADDR_MASK   = 2'd3;

  typedef struct packed {
    logic shiftEn;
    logic commit;
  } gapStrobe_t;
endpackage

// File: rtl/smii_gap_ctrl.sv
module smii_gap_ctrl
  import smii_gap_pkg::*;
#(
  parameter int STATUS_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeSmii,
  input  logic       syncIn,
  input  logic       rxBit,
  output gapStrobe_t strobes
);
  localparam int LAST = STATUS_W + 1;
  localparam int CNT_W = $clog2(LAST + 1);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] DV_C = CNT_W'(1);
  localparam logic [CNT_W-1:0] FIRST_DATA_C = CNT_W'(2);

  logic             active;
  logic [CNT_W-1:0] bitCnt;
  logic             dvQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
      dvQ    <= 1'b0;
    end else if (syncIn) begin
      active <= 1'b1;
      bitCnt <= DV_C;
      dvQ    <= 1'b0;
    end else if (active) begin
      if (bitCnt == DV_C) dvQ <= rxBit;
      if (bitCnt == LAST_C) active <= 1'b0;
      else bitCnt <= bitCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.shiftEn = active && !syncIn && (bitCnt >= FIRST_DATA_C);
    strobes.commit  = active && !syncIn && (bitCnt == LAST_C) && !dvQ && modeSmii;
  end
endmodule

// File: rtl/smii_gap_datapath.sv
module smii_gap_datapath
  import smii_gap_pkg::*;
#(
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxBit,
  input  gapStrobe_t          strobes,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [STATUS_W-1:0] regWrData,
  output logic [STATUS_W-1:0] regRdData,
  output logic [STATUS_W-1:0] statusQ,
  output logic [STATUS_W-1:0] eventQ,
  output logic [STATUS_W-1:0] maskQ,
  output logic                irqOut
);
  logic [STATUS_W-1:0] shiftQ;
  logic [STATUS_W-1:0] expectQ;
  logic [STATUS_W-1:0] shiftNext;
  logic [STATUS_W-1:0] mismatch;
  logic [STATUS_W-1:0] clearBits;

  always_comb begin
    shiftNext = {rxBit, shiftQ[STATUS_W-1:1]};
    mismatch  = strobes.commit ? (shiftNext ^ expectQ) : '0;
    clearBits = (regWrEn && regAddr == ADDR_EVENT) ? regWrData : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ  <= '0;
      statusQ <= '0;
      expectQ <= '0;
      eventQ  <= '0;
      maskQ   <= '0;
      irqOut  <= 1'b0;
    end else begin
      if (strobes.shiftEn) shiftQ <= shiftNext;
      if (strobes.commit) statusQ <= shiftNext;
      if (regWrEn && regAddr == ADDR_EXPECT) expectQ <= regWrData;
      if (regWrEn && regAddr == ADDR_MASK) maskQ <= regWrData;
      eventQ <= (eventQ & ~clearBits) | mismatch;
      irqOut <= |(eventQ & maskQ);
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_STATUS: regRdData = statusQ;
      ADDR_EXPECT: regRdData = expectQ;
      ADDR_EVENT:  regRdData = eventQ;
      default:     regRdData = maskQ;
    endcase
  end
endmodule

// File: rtl/smii_gap_mon.sv
module smii_gap_mon
  import smii_gap_pkg::*;
#(
  parameter int STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modeSmii,
  input  logic                syncIn,
  input  logic                rxBit,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [STATUS_W-1:0] regWrData,
  output logic [STATUS_W-1:0] regRdData,
  output logic                irqOut
);
  gapStrobe_t          strobes;
  logic                commitStrobe;
  logic [STATUS_W-1:0] statusQ;
  logic [STATUS_W-1:0] eventQ;
  logic [STATUS_W-1:0] maskQ;

  assign commitStrobe = strobes.commit;

  smii_gap_ctrl #(.STATUS_W(STATUS_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .modeSmii(modeSmii), .syncIn(syncIn),
    .rxBit(rxBit), .strobes(strobes)
  );

  smii_gap_datapath #(.STATUS_W(STATUS_W)) i_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strobes(strobes),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .statusQ(statusQ), .eventQ(eventQ),
    .maskQ(maskQ), .irqOut(irqOut)
  );
endmodule

// File: rtl/smii_gap_mon_chk.sv
module smii_gap_mon_chk
  import smii_gap_pkg::*;
#(
  parameter int STATUS_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                modeSmii,
  input logic                regWrEn,
  input logic [1:0]          regAddr,
  input logic [STATUS_W-1:0] statusQ,
  input logic [STATUS_W-1:0] eventQ,
  input logic [STATUS_W-1:0] maskQ,
  input logic                commitStrobe,
  input logic                irqOut
);
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(|(eventQ & maskQ)));

  assert_event_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrEn && regAddr == ADDR_EVENT) |-> ((eventQ & $past(eventQ)) == $past(eventQ)));

  assert_event_needs_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(commitStrobe) |-> ((eventQ & ~$past(eventQ)) == '0));

  assert_status_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(commitStrobe) |-> $stable(statusQ));

  assert_mode_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!modeSmii) |-> $stable(statusQ));
endmodule

bind smii_gap_mon smii_gap_mon_chk #(.STATUS_W(STATUS_W)) i_chk (
  .clk(clk), .rstN(rstN), .modeSmii(modeSmii), .regWrEn(regWrEn),
  .regAddr(regAddr), .statusQ(statusQ), .eventQ(eventQ), .maskQ(maskQ),
  .commitStrobe(commitStrobe), .irqOut(irqOut)
);

// File: tb/test_smii_gap_mon.sv
`timescale 1ns/1ps
module test_smii_gap_mon;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSmii = 1'b1;
  logic       syncIn = 1'b0;
  logic       rxBit = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       irqOut;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  smii_gap_mon #(.STATUS_W(8)) i_smii_gap_mon (
    .clk(clk), .rstN(rstN), .modeSmii(modeSmii), .syncIn(syncIn),
    .rxBit(rxBit), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [7:0] exp, input string tag);
    regAddr = a;
    #0.5;
    check(tag, regRdData, exp);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sendBits(input logic dv, input logic [7:0] data, input int nBits,
                          input logic clrEn, input logic [7:0] clr);
    for (int i = 0; i < nBits; i++) begin
      syncIn = (i == 0);
      rxBit = (i == 0) ? 1'b1 : (i == 1) ? dv : data[i-2];
      if (i == 9 && clrEn) begin
        regWrEn = 1'b1; regAddr = 2'd2; regWrData = clr;
      end
      @(posedge clk); @(negedge clk);
      regWrEn = 1'b0;
    end
    syncIn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    for (int a = 0; a < 4; a++) readCheck(2'(a), 8'h00, "R8 reset reg");
    check("R8 reset irq", {7'd0, irqOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R9 register readback and ignored status writes
    writeReg(2'd1, 8'hA5);
    writeReg(2'd3, 8'hFF);
    readCheck(2'd1, 8'hA5, "R9 expected readback");
    readCheck(2'd3, 8'hFF, "R9 mask readback");
    writeReg(2'd0, 8'h3C);
    readCheck(2'd0, 8'h00, "R9 status write ignored");

    // R1 R4 R6 sweep over every status byte
    for (int v = 0; v < 256; v++) begin
      writeReg(2'd2, 8'hFF);
      sendBits(1'b0, 8'(v), 10, 1'b0, 8'h00);
      readCheck(2'd0, 8'(v), "R1 status capture");
      readCheck(2'd2, 8'(v) ^ 8'hA5, "R4 event bits");
      @(negedge clk);
      check("R6 irq", {7'd0, irqOut}, {7'd0, (8'(v) != 8'hA5)});
    end

    // R5 clear of selected bits only
    writeReg(2'd2, 8'hFF);
    sendBits(1'b0, 8'h5A, 10, 1'b0, 8'h00);
    readCheck(2'd2, 8'hFF, "R4 all mismatch");
    writeReg(2'd2, 8'h0F);
    readCheck(2'd2, 8'hF0, "R5 partial clear");
    // R5 new mismatch wins over simultaneous clear
    sendBits(1'b0, 8'hA4, 10, 1'b1, 8'hFF);
    readCheck(2'd2, 8'h01, "R5 set beats clear");

    // R6 mask gating
    writeReg(2'd3, 8'h00);
    @(negedge clk);
    check("R6 masked irq", {7'd0, irqOut}, 8'h00);
    writeReg(2'd3, 8'h01);
    @(negedge clk);
    check("R6 unmasked irq", {7'd0, irqOut}, 8'h01);
    writeReg(2'd3, 8'hFF);
    writeReg(2'd2, 8'hFF);

    // R2 data-valid segment ignored
    sendBits(1'b0, 8'hA5, 10, 1'b0, 8'h00);
    sendBits(1'b1, 8'h33, 10, 1'b0, 8'h00);
    readCheck(2'd0, 8'hA5, "R2 frame data status");
    readCheck(2'd2, 8'h00, "R2 frame data event");
    @(negedge clk);
    check("R2 frame data irq", {7'd0, irqOut}, 8'h00);

    // R3 mode off ignored
    modeSmii = 1'b0;
    sendBits(1'b0, 8'h66, 10, 1'b0, 8'h00);
    modeSmii = 1'b1;
    readCheck(2'd0, 8'hA5, "R3 mode off status");
    readCheck(2'd2, 8'h00, "R3 mode off event");

    // R7 restart on sync, trailing bits ignored
    sendBits(1'b0, 8'h11, 6, 1'b0, 8'h00);
    sendBits(1'b0, 8'hC3, 10, 1'b0, 8'h00);
    readCheck(2'd0, 8'hC3, "R7 restart capture");
    rxBit = 1'b0;
    repeat (12) begin
      @(negedge clk);
      rxBit = ~rxBit;
    end
    readCheck(2'd0, 8'hC3, "R7 trailing bits");
    readCheck(2'd2, 8'hC3 ^ 8'hA5, "R7 event after restart");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule